// File: doc/BRIEF.md
# Coprocessor Configuration and Cycle-Count Controller

This block sits on the processor side of a multi-cycle reconfigurable coprocessor. It takes instructions from the processor's decoder one at a time and handles each one. A configuration instruction selects an array configuration and loads it when it is not already resident. Two move instructions carry a single word to the array or bring one back. A start instruction launches the array for a given number of cycles. A save instruction and a restore instruction read and reload the cycle counter, so that an operation that is still running can be swapped out and resumed later.

A down-counter holds the number of cycles the array still has to run, and the array run enable stays high while that counter is nonzero. A per-instruction interlock bit decides how the processor behaves during the run. With the bit set, a start instruction or a read from the array holds the processor until the counter reaches zero. With the bit clear, the processor keeps issuing instructions while the array runs. A configuration miss stalls the processor for a fixed load time. An instruction counts as accepted in any cycle where `op_valid` is high and `stall` is low. While `stall` is high, the presented instruction has no effect.

Top module: `copro_seq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `stall`, `run_en`, `cfg_loading`, `cfg_fetch`, `array_wr`, `array_rd` and `proc_rvalid` are all low.
- R2: An accepted configuration instruction (`op_code` 1) with `cfg_hit` high does not raise `cfg_fetch`, `cfg_loading` or `stall`. The next instruction is accepted in the following cycle.
- R3: An accepted configuration instruction (`op_code` 1) with `cfg_hit` low pulses `cfg_fetch` in its accept cycle, with `cfg_fetch_id` equal to `op_cfg_id`. `cfg_loading` and `stall` are then high for exactly LOAD_CYC (default 16) cycles.
- R4: An accepted put instruction (`op_code` 2) raises `array_wr` for that one cycle, with `array_wdata` equal to `op_data`.
- R5: An accepted start instruction (`op_code` 4) loads the counter from `op_data[CNT_W-1:0]`. `run_en` is then high for exactly that many cycles, starting in the next cycle. A count of zero does not raise `run_en`.
- R6: A start instruction with `op_interlock` high stalls the processor for every cycle in which `run_en` is high after it. With `op_interlock` low it causes no stall, and other instructions are accepted while the array runs.
- R7: A get instruction (`op_code` 3) with `op_interlock` high, presented while the counter is nonzero, holds `stall` high and `array_rd` low until the counter reaches zero. A get is accepted at once when `op_interlock` is low or the counter is zero. When a get is accepted, `array_rd` is high in that cycle, and in the next cycle `proc_rvalid` is high with `proc_rdata` equal to the `array_rdata` sampled in the accept cycle.
- R8: An accepted save instruction (`op_code` 5) gives, in the next cycle, `proc_rvalid` high and `proc_rdata` equal to the counter value of the accept cycle, zero-extended to DATA_W.
- R9: An accepted restore instruction (`op_code` 6) loads the counter from `op_data[CNT_W-1:0]`. Countdown and `run_en` then continue from that value.
- R10: An instruction presented while `stall` is high raises none of `array_wr`, `array_rd` or `cfg_fetch`, and does not change the counter. It takes effect only in the first cycle in which `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An instruction is presented |
| op_code | input | 3 | 0 none, 1 configure, 2 put, 3 get, 4 start, 5 save, 6 restore |
| op_interlock | input | 1 | Wait for the counter to reach zero (start, get) |
| op_data | input | DATA_W | Word to put, start count, or restore value |
| op_cfg_id | input | CFG_W | Configuration named by a configure instruction |
| cfg_hit | input | 1 | The named configuration is already resident |
| cfg_fetch | output | 1 | Request to load the named configuration |
| cfg_fetch_id | output | CFG_W | Configuration to load |
| cfg_loading | output | 1 | A configuration load is in progress |
| array_wr | output | 1 | Write strobe toward the array |
| array_wdata | output | DATA_W | Word written to the array |
| array_rd | output | 1 | Read strobe toward the array |
| array_rdata | input | DATA_W | Word read from the array |
| run_en | output | 1 | Array run enable |
| stall | output | 1 | Processor suspend |
| proc_rvalid | output | 1 | Result word valid |
| proc_rdata | output | DATA_W | Result of a get or save |

## Verification
The bench goes after the edges of the countdown. A start count of zero must give no run cycle at all, and a design that starts one cycle early or late shows a run length one off from the count. An interlocked get is issued while the array is still running, and a design that reads early returns a word before the counter has expired. A configuration miss is followed by a put that is already presented during the load, so a design whose load is one cycle too short, or that lets the stalled put through, shows a write strobe in the wrong cycle. Save and restore are issued in the middle of a run, so a design that captures the counter in the wrong cycle, or does not resume from the restored value, reports a count that is off.

// File: rtl/copro_pkg.sv
package copro_pkg;
   typedef enum logic [2:0] {
      CX_NOP     = 3'd0,
      CX_CFG     = 3'd1,
      CX_PUT     = 3'd2,
      CX_GET     = 3'd3,
      CX_GO      = 3'd4,
      CX_SAVE    = 3'd5,
      CX_RESTORE = 3'd6
   } cx_op_e;
endpackage

// File: rtl/copro_cycle_ctr.sv
module copro_cycle_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             run
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign run = (cnt != '0);
endmodule

// File: rtl/copro_cfg_timer.sv
module copro_cfg_timer #(
   parameter int LOAD_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int LD_W = $clog2(LOAD_CYC + 1);
   localparam logic [LD_W-1:0] LD_INIT = LD_W'(LOAD_CYC);

   logic [LD_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (start)
         left_q <= LD_INIT;
      else if (left_q != '0)
         left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);
endmodule

// File: rtl/copro_issue.sv
module copro_issue
   import copro_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_valid,
   input  logic [2:0] op_code,
   input  logic       op_interlock,
   input  logic       cfg_hit,
   input  logic       cnt_zero,
   input  logic       load_busy,
   output logic       stall,
   output logic       acc_cfg_miss,
   output logic       acc_put,
   output logic       acc_get,
   output logic       acc_go,
   output logic       acc_save,
   output logic       acc_restore
);
   cx_op_e op;
   logic   wait_q;
   logic   get_hold;
   logic   accept;

   assign op = cx_op_e'(op_code);

   always_comb begin
      get_hold     = op_valid && (op == CX_GET) && op_interlock && !cnt_zero;
      stall        = load_busy || (wait_q && !cnt_zero) || get_hold;
      accept       = op_valid && !stall;
      acc_cfg_miss = accept && (op == CX_CFG) && !cfg_hit;
      acc_put      = accept && (op == CX_PUT);
      acc_get      = accept && (op == CX_GET);
      acc_go       = accept && (op == CX_GO);
      acc_save     = accept && (op == CX_SAVE);
      acc_restore  = accept && (op == CX_RESTORE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wait_q <= 1'b0;
      else if (acc_go)
         wait_q <= op_interlock;
      else if (acc_restore || cnt_zero)
         wait_q <= 1'b0;
   end
endmodule

// File: rtl/copro_seq_ctrl.sv
module copro_seq_ctrl #(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 16,
   parameter int CFG_W    = 4,
   parameter int LOAD_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic              op_interlock,
   input  logic [DATA_W-1:0] op_data,
   input  logic [CFG_W-1:0]  op_cfg_id,
   input  logic              cfg_hit,
   output logic              cfg_fetch,
   output logic [CFG_W-1:0]  cfg_fetch_id,
   output logic              cfg_loading,
   output logic              array_wr,
   output logic [DATA_W-1:0] array_wdata,
   output logic              array_rd,
   input  logic [DATA_W-1:0] array_rdata,
   output logic              run_en,
   output logic              stall,
   output logic              proc_rvalid,
   output logic [DATA_W-1:0] proc_rdata
);
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 1 and DATA_W");
   end
   if (LOAD_CYC < 1) begin : g_bad_load
      $error("LOAD_CYC must be at least 1");
   end
   if (CFG_W < 1) begin : g_bad_cfg_w
      $error("CFG_W must be at least 1");
   end

   logic              acc_cfg_miss, acc_put, acc_get, acc_go, acc_save, acc_restore;
   logic              ctr_load;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] cnt_word;
   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;

   copro_issue u_issue (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_valid     (op_valid),
      .op_code      (op_code),
      .op_interlock (op_interlock),
      .cfg_hit      (cfg_hit),
      .cnt_zero     (!run_en),
      .load_busy    (cfg_loading),
      .stall        (stall),
      .acc_cfg_miss (acc_cfg_miss),
      .acc_put      (acc_put),
      .acc_get      (acc_get),
      .acc_go       (acc_go),
      .acc_save     (acc_save),
      .acc_restore  (acc_restore)
   );

   assign ctr_load = acc_go || acc_restore;

   copro_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load),
      .load_val (op_data[CNT_W-1:0]),
      .cnt      (cnt_q),
      .run      (run_en)
   );

   copro_cfg_timer #(.LOAD_CYC(LOAD_CYC)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .start (acc_cfg_miss),
      .busy  (cfg_loading)
   );

   if (CNT_W == DATA_W) begin : g_cnt_full
      assign cnt_word = cnt_q;
   end else begin : g_cnt_ext
      assign cnt_word = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= acc_get || acc_save;
         if (acc_get)
            rdata_q <= array_rdata;
         else if (acc_save)
            rdata_q <= cnt_word;
      end
   end

   assign cfg_fetch    = acc_cfg_miss;
   assign cfg_fetch_id = op_cfg_id;
   assign array_wr     = acc_put;
   assign array_wdata  = op_data;
   assign array_rd     = acc_get;
   assign proc_rvalid  = rvalid_q;
   assign proc_rdata   = rdata_q;
endmodule

// File: rtl/copro_seq_ctrl_chk.sv
module copro_seq_ctrl_chk
   import copro_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_code,
   input logic              op_interlock,
   input logic [DATA_W-1:0] op_data,
   input logic              cfg_hit,
   input logic              cfg_fetch,
   input logic              cfg_loading,
   input logic              array_wr,
   input logic              array_rd,
   input logic              run_en,
   input logic              stall,
   input logic              proc_rvalid,
   input logic [CNT_W-1:0]  cnt_q
);
   logic acc_restore;
   logic acc_cfg_hit;
   assign acc_restore = op_valid && !stall && (op_code == CX_RESTORE);
   assign acc_cfg_hit = op_valid && !stall && (op_code == CX_CFG) && cfg_hit;

   p_fetch_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_fetch |=> (cfg_loading && stall));

   p_hit_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_cfg_hit |=> !cfg_loading);

   p_stalled_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (!array_wr && !array_rd && !cfg_fetch));

   p_get_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == CX_GET && op_interlock && run_en) |-> (stall && !array_rd));

   p_get_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      array_rd |=> proc_rvalid);

   p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !(op_valid && !stall && (op_code == CX_GO || op_code == CX_RESTORE)))
      |=> (cnt_q == $past(cnt_q) - 1'b1));

   p_restore_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_restore |=> (cnt_q == $past(op_data[CNT_W-1:0])));
endmodule

bind copro_seq_ctrl copro_seq_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid     (op_valid),
   .op_code      (op_code),
   .op_interlock (op_interlock),
   .op_data      (op_data),
   .cfg_hit      (cfg_hit),
   .cfg_fetch    (cfg_fetch),
   .cfg_loading  (cfg_loading),
   .array_wr     (array_wr),
   .array_rd     (array_rd),
   .run_en       (run_en),
   .stall        (stall),
   .proc_rvalid  (proc_rvalid),
   .cnt_q        (cnt_q)
);

// File: tb/copro_seq_ctrl_test.sv
`timescale 1ns/1ps
module copro_seq_ctrl_test;
   localparam int DW = 32;
   localparam int CW = 16;
   localparam int IW = 4;
   localparam int LC = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [2:0]    op_code = 3'd0;
   logic          op_interlock = 1'b0;
   logic [DW-1:0] op_data = '0;
   logic [IW-1:0] op_cfg_id = '0;
   logic          cfg_hit = 1'b0;
   logic          cfg_fetch, cfg_loading, array_wr, array_rd, run_en, stall, proc_rvalid;
   logic [IW-1:0] cfg_fetch_id;
   logic [DW-1:0] array_wdata, proc_rdata;
   logic [DW-1:0] array_rdata = 32'hA5A5_0000;

   int    n_chk = 0;
   int    n_bad = 0;
   int    run_seen = 0;
   int    stall_seen = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   copro_seq_ctrl #(.DATA_W(DW), .CNT_W(CW), .CFG_W(IW), .LOAD_CYC(LC)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_interlock(op_interlock), .op_data(op_data), .op_cfg_id(op_cfg_id),
      .cfg_hit(cfg_hit), .cfg_fetch(cfg_fetch), .cfg_fetch_id(cfg_fetch_id),
      .cfg_loading(cfg_loading), .array_wr(array_wr), .array_wdata(array_wdata),
      .array_rd(array_rd), .array_rdata(array_rdata), .run_en(run_en),
      .stall(stall), .proc_rvalid(proc_rvalid), .proc_rdata(proc_rdata)
   );

   task automatic cmp(string req, string sig, logic [DW-1:0] got, logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s got %h expected %h", req, sig, got, exp);
      end
   endtask

   // Reference model state
   int            m_cnt = 0;
   bit            m_wait = 0;
   int            m_ld = 0;
   bit            m_rv = 0;
   logic [DW-1:0] m_res = '0;

   always begin
      int            n_cnt, n_ld;
      bit            n_wait, n_rv;
      logic [DW-1:0] n_res;
      bit            hold, e_stall, acc;
      @(negedge clk);
      #1;
      if (!rst_n) begin
         cmp("R1", "stall", {31'd0, stall}, '0);
         cmp("R1", "run_en", {31'd0, run_en}, '0);
         cmp("R1", "cfg_loading", {31'd0, cfg_loading}, '0);
         cmp("R1", "proc_rvalid", {31'd0, proc_rvalid}, '0);
         m_cnt = 0; m_wait = 0; m_ld = 0; m_rv = 0; m_res = '0;
      end else begin
         hold    = op_valid && op_code == 3'd3 && op_interlock && m_cnt != 0;
         e_stall = (m_ld != 0) || (m_wait && m_cnt != 0) || hold;
         acc     = op_valid && !e_stall;
         cmp(cur_req, "stall", {31'd0, stall}, {31'd0, e_stall});
         cmp(cur_req, "run_en", {31'd0, run_en}, {31'd0, m_cnt != 0});
         cmp(cur_req, "cfg_loading", {31'd0, cfg_loading}, {31'd0, m_ld != 0});
         cmp(cur_req, "cfg_fetch", {31'd0, cfg_fetch},
             {31'd0, acc && op_code == 3'd1 && !cfg_hit});
         if (cfg_fetch) cmp(cur_req, "cfg_fetch_id", {28'd0, cfg_fetch_id}, {28'd0, op_cfg_id});
         cmp(cur_req, "array_wr", {31'd0, array_wr}, {31'd0, acc && op_code == 3'd2});
         if (array_wr) cmp(cur_req, "array_wdata", array_wdata, op_data);
         cmp(cur_req, "array_rd", {31'd0, array_rd}, {31'd0, acc && op_code == 3'd3});
         cmp(cur_req, "proc_rvalid", {31'd0, proc_rvalid}, {31'd0, m_rv});
         if (m_rv) cmp(cur_req, "proc_rdata", proc_rdata, m_res);
         if (run_en) run_seen++;
         if (stall) stall_seen++;
         n_ld   = (acc && op_code == 3'd1 && !cfg_hit) ? LC : (m_ld > 0 ? m_ld - 1 : 0);
         n_cnt  = (acc && (op_code == 3'd4 || op_code == 3'd6)) ? int'(op_data[CW-1:0])
                  : (m_cnt > 0 ? m_cnt - 1 : 0);
         n_wait = (acc && op_code == 3'd4) ? op_interlock
                  : ((acc && op_code == 3'd6) || m_cnt == 0) ? 1'b0 : m_wait;
         n_rv   = acc && (op_code == 3'd3 || op_code == 3'd5);
         n_res  = (acc && op_code == 3'd3) ? array_rdata
                  : (acc && op_code == 3'd5) ? DW'(m_cnt) : m_res;
         @(posedge clk);
         m_ld = n_ld; m_cnt = n_cnt; m_wait = n_wait; m_rv = n_rv; m_res = n_res;
      end
   end

   // Present an instruction and hold it until it is accepted.
   task automatic issue(logic [2:0] code, bit il, logic [DW-1:0] data,
                        logic [IW-1:0] id = '0, bit hit = 1'b1);
      @(negedge clk);
      op_valid = 1'b1; op_code = code; op_interlock = il; op_data = data;
      op_cfg_id = id; cfg_hit = hit;
      array_rdata = array_rdata + 32'h11;
      #1;
      while (stall) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         op_valid = 1'b0; op_code = 3'd0; op_interlock = 1'b0;
      end
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      cur_req = "R2";
      stall_seen = 0;
      issue(3'd1, 0, '0, 4'd3, 1'b1);
      idle(3);
      cmp("R2", "stall cycles after hit", DW'(stall_seen), '0);

      cur_req = "R3";
      stall_seen = 0;
      issue(3'd1, 0, '0, 4'd9, 1'b0);
      idle(LC + 4);
      cmp("R3", "stall cycles after miss", DW'(stall_seen), DW'(LC));

      cur_req = "R10";
      issue(3'd1, 0, '0, 4'd5, 1'b0);
      issue(3'd2, 0, 32'hDEAD_BEEF);
      idle(2);

      cur_req = "R4";
      issue(3'd2, 0, 32'h1234_5678);
      issue(3'd2, 0, 32'hFFFF_0001);
      idle(2);

      cur_req = "R5";
      run_seen = 0;
      issue(3'd4, 0, 32'd5);
      idle(8);
      cmp("R5", "run cycles for count 5", DW'(run_seen), 32'd5);
      run_seen = 0;
      issue(3'd4, 0, 32'd0);
      idle(3);
      cmp("R5", "run cycles for count 0", DW'(run_seen), 32'd0);

      cur_req = "R6";
      issue(3'd4, 0, 32'd6);
      issue(3'd2, 0, 32'h0000_00AB);
      issue(3'd2, 0, 32'h0000_00CD);
      idle(6);
      stall_seen = 0;
      issue(3'd4, 1, 32'd7);
      issue(3'd2, 0, 32'h0000_0077);
      idle(2);
      cmp("R6", "interlocked stall cycles", DW'(stall_seen), 32'd7);

      cur_req = "R7";
      issue(3'd4, 0, 32'd10);
      issue(3'd3, 1, '0);
      issue(3'd4, 0, 32'd4);
      issue(3'd3, 0, '0);
      idle(6);
      issue(3'd3, 1, '0);
      idle(2);

      cur_req = "R8";
      issue(3'd4, 0, 32'd20);
      idle(3);
      issue(3'd5, 0, '0);
      issue(3'd5, 0, '0);
      idle(20);
      issue(3'd5, 0, '0);
      idle(2);

      cur_req = "R9";
      issue(3'd4, 0, 32'd30);
      idle(2);
      issue(3'd6, 0, 32'hABCD_0009);
      issue(3'd5, 0, '0);
      run_seen = 0;
      idle(12);
      issue(3'd6, 0, 32'd3);
      issue(3'd3, 1, '0);
      idle(3);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule